// File: doc/BRIEF.md
# Quad DAC Serial Register Interface

This block is the digital front end of a four-channel, 12-bit voltage-output converter. A host sends 16-bit words over a three-wire serial link made of a shift clock, a data line and an active-low select. A separate active-low load strobe copies the word held in the shift register into the data register of one of four channels. A two-bit address at the head of the word chooses that channel. The four channel registers drive the converter codes. Writing a word and committing it are separate steps, so the host can move all channels at chosen moments.

An active-low clear forces every channel register to zero-scale or to midscale, as chosen by a select input. The clear does not touch the shift register, so a strobe after the clear can restore the last shifted word. Every pin is brought into a fast system clock domain through a synchronizer. The block finds edges by comparing successive synchronized samples. The shift clock is the OR of the serial clock and the select line, so a select that rises while the serial clock is low clocks in one extra bit.

Top module: `qdac_serial_front`

## Requirements
- R1: While `rst` is high, all four channel codes are set to 0x000 on the next clock edge and `proto_err` is low.
- R2: A word is 16 bits, sent MSB first. Bit 15 down to bit 14 is the channel address, bits 13:12 are ignored, and bits 11:0 are the code. Address 00 writes channel A (`dac_codes[11:0]`), 01 writes B (`[23:12]`), 10 writes C (`[35:24]`) and 11 writes D (`[47:36]`).
- R3: A load strobe changes only the addressed channel. The other three keep their codes.
- R4: A load always uses the last 16 bits shifted. Earlier bits of a longer burst have no effect.
- R5: While `cs_n` is high, toggling `sclk` and `sdin` shifts nothing. A later load commits the word shifted before `cs_n` rose.
- R6: A bit is shifted on each rising edge of (`sclk` OR `cs_n`). A rise of `cs_n` while `sclk` is low therefore shifts in the current `sdin` value as an extra bit.
- R7: A falling edge of `ldac_n` performs the load whether `cs_n` is high or low.
- R8: While `clr_n` is low, all four codes are forced to 0x000 if `clr_mid` is low, or to 0x800 if it is high.
- R9: After `clr_n` is released, the codes hold the clear value until the next load strobe. That strobe commits the shift register contents, which the clear left unchanged.
- R10: A falling edge of `ldac_n` that occurs while `clr_n` is low is discarded. The codes keep the clear value after the clear is released.
- R11: `proto_err` pulses high for one cycle for each shift that occurs while `ldac_n` is low. It stays low otherwise. Shifting while the strobe is low does not load a channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples every pin |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial shift clock; bits are captured on its rising edge |
| sdin | input | 1 | Serial data, MSB first |
| cs_n | input | 1 | Active-low select, ORed with `sclk` |
| ldac_n | input | 1 | Active-low load strobe; acts on its falling edge |
| clr_n | input | 1 | Active-low clear of all channel registers |
| clr_mid | input | 1 | Clear target: 0 gives zero-scale, 1 gives midscale |
| dac_codes | output | 48 | Four 12-bit channel codes, channel A in the low bits |
| proto_err | output | 1 | One-cycle pulse when a bit is shifted while the strobe is low |

## Verification
The hardest case to reach from the ports is the false bit. It needs `cs_n` to rise while `sclk` sits low after the final data bit, a sequence that a well-behaved host never produces. The bench builds it on purpose: it leaves the clock low after the sixteenth bit, sets `sdin`, then raises the select. It then commits the word, which now carries a different address, and checks that the channel picked by the shifted-by-one word receives the shifted code. The clear and strobe overlap is reached the same way: `ldac_n` is lowered during a clear and raised only after the clear has been released.

// File: rtl/qdac_pkg.sv
package qdac_pkg;

    localparam int unsigned DEF_ADDR_W = 2;
    localparam int unsigned DEF_PAD_W  = 2;
    localparam int unsigned DEF_CODE_W = 12;
    localparam int unsigned DEF_SYNC   = 2;

    // Pin bundle carried through the synchronizer
    typedef struct packed {
        logic clr_mid;
        logic clr_n;
        logic ldac_n;
        logic sdin;
        logic cs_n;
        logic sclk;
    } pins_t;

    localparam pins_t PINS_IDLE = '{clr_mid: 1'b0, clr_n: 1'b1, ldac_n: 1'b1,
                                    sdin: 1'b0, cs_n: 1'b1, sclk: 1'b1};

    // Action taken by the channel bank in one cycle
    typedef enum logic [1:0] {
        CMD_HOLD  = 2'd0,
        CMD_LOAD  = 2'd1,
        CMD_CLEAR = 2'd2
    } bank_cmd_e;

    // Effective shift clock: select gates the serial clock high
    function automatic logic shift_clock(pins_t p);
        return p.sclk | p.cs_n;
    endfunction

endpackage

// File: rtl/qdac_sync.sv
module qdac_sync #(
    parameter int          W       = 6,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stage;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage <= {STAGES{RST_VAL}};
        end else begin
            stage[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                stage[i] <= stage[i-1];
            end
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/qdac_shifter.sv
module qdac_shifter #(
    parameter int FRAME_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               shift_clk_s,
    input  logic               sdin_s,
    input  logic               ldac_n_s,
    output logic [FRAME_W-1:0] shreg,
    output logic               proto_err
);
    logic shift_clk_q;
    logic shift_rise;

    assign shift_rise = shift_clk_s & ~shift_clk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shift_clk_q <= 1'b1;
            shreg       <= '0;
            proto_err   <= 1'b0;
        end else begin
            shift_clk_q <= shift_clk_s;
            proto_err   <= shift_rise & ~ldac_n_s;
            if (shift_rise) begin
                shreg <= {shreg[FRAME_W-2:0], sdin_s};
            end
        end
    end

    AST_SHIFT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !shift_rise |=> $stable(shreg)); // R5

    AST_SHIFT_ENTRY: assert property (@(posedge clk) disable iff (rst)
        shift_rise |=> (shreg[0] == $past(sdin_s))); // R6

    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (rst)
        proto_err |-> $past(!ldac_n_s)); // R11
endmodule

// File: rtl/qdac_regbank.sv
module qdac_regbank
    import qdac_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int CODE_W = 12,
    localparam int NCH   = 1 << ADDR_W
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        ldac_n_s,
    input  logic                        clr_n_s,
    input  logic                        clr_mid_s,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [CODE_W-1:0]           code,
    output logic [NCH-1:0][CODE_W-1:0]  regs
);
    localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(1) << (CODE_W - 1);

    logic      ldac_q;
    logic      load_edge;
    bank_cmd_e cmd;

    assign load_edge = ldac_q & ~ldac_n_s;

    // Clear outranks a coincident load
    always_comb begin
        if (!clr_n_s)       cmd = CMD_CLEAR;
        else if (load_edge) cmd = CMD_LOAD;
        else                cmd = CMD_HOLD;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ldac_q <= 1'b1;
            regs   <= '0;
        end else begin
            ldac_q <= ldac_n_s;
            for (int ch = 0; ch < NCH; ch++) begin
                case (cmd)
                    CMD_CLEAR: regs[ch] <= clr_mid_s ? MID_CODE : '0;
                    CMD_LOAD:  if (addr == ADDR_W'(ch)) regs[ch] <= code;
                    default:   ;
                endcase
            end
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_chk
        AST_CLEAR_VALUE: assert property (@(posedge clk) disable iff (rst)
            !clr_n_s |=> (regs[g] == ($past(clr_mid_s) ? MID_CODE : '0))); // R8

        AST_LOAD_TARGET: assert property (@(posedge clk) disable iff (rst)
            (clr_n_s && load_edge && addr == ADDR_W'(g)) |=> (regs[g] == $past(code))); // R2

        AST_OTHERS_KEEP: assert property (@(posedge clk) disable iff (rst)
            (clr_n_s && !(load_edge && addr == ADDR_W'(g))) |=> $stable(regs[g])); // R3
    end
endmodule

// File: rtl/qdac_serial_front.sv
module qdac_serial_front
    import qdac_pkg::*;
#(
    parameter int ADDR_W      = DEF_ADDR_W,
    parameter int PAD_W       = DEF_PAD_W,
    parameter int CODE_W      = DEF_CODE_W,
    parameter int SYNC_STAGES = DEF_SYNC,
    localparam int FRAME_W    = ADDR_W + PAD_W + CODE_W,
    localparam int NCH        = 1 << ADDR_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    sclk,
    input  logic                    sdin,
    input  logic                    cs_n,
    input  logic                    ldac_n,
    input  logic                    clr_n,
    input  logic                    clr_mid,
    output logic [NCH*CODE_W-1:0]   dac_codes,
    output logic                    proto_err
);
    localparam int PINS_W = $bits(pins_t);

    pins_t raw_pins;
    pins_t syn_pins;
    logic [FRAME_W-1:0]          shreg;
    logic [NCH-1:0][CODE_W-1:0]  regs;
    logic [PAD_W-1:0]            unused_pad_bits;

    assign raw_pins = '{clr_mid: clr_mid, clr_n: clr_n, ldac_n: ldac_n,
                        sdin: sdin, cs_n: cs_n, sclk: sclk};

    qdac_sync #(
        .W       (PINS_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PINS_IDLE)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_pins),
        .q   (syn_pins)
    );

    qdac_shifter #(
        .FRAME_W (FRAME_W)
    ) u_shifter (
        .clk         (clk),
        .rst         (rst),
        .shift_clk_s (shift_clock(syn_pins)),
        .sdin_s      (syn_pins.sdin),
        .ldac_n_s    (syn_pins.ldac_n),
        .shreg       (shreg),
        .proto_err   (proto_err)
    );

    assign unused_pad_bits = shreg[CODE_W +: PAD_W];

    qdac_regbank #(
        .ADDR_W (ADDR_W),
        .CODE_W (CODE_W)
    ) u_bank (
        .clk       (clk),
        .rst       (rst),
        .ldac_n_s  (syn_pins.ldac_n),
        .clr_n_s   (syn_pins.clr_n),
        .clr_mid_s (syn_pins.clr_mid),
        .addr      (shreg[FRAME_W-1 -: ADDR_W]),
        .code      (shreg[CODE_W-1:0]),
        .regs      (regs)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_out
        assign dac_codes[g*CODE_W +: CODE_W] = regs[g];
    end

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (dac_codes == '0 && !proto_err)); // R1
endmodule

// File: tb/qdac_serial_front_bench.sv
module qdac_serial_front_bench;
    localparam int CODE_W  = 12;
    localparam int FRAME_W = 16;
    localparam int NCH     = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sclk = 1'b1, sdin = 1'b0, cs_n = 1'b1, ldac_n = 1'b1;
    logic clr_n = 1'b1, clr_mid = 1'b0;
    logic [NCH*CODE_W-1:0] dac_codes;
    logic proto_err;

    int checks = 0, errors = 0, err_pulses = 0, exp_pulses = 0;
    bit done = 1'b0;
    logic [FRAME_W-1:0] sh_m = '0;
    logic [CODE_W-1:0]  exp_m [NCH];

    always #10 clk = ~clk;

    qdac_serial_front u_qdac_serial_front (
        .clk (clk), .rst (rst), .sclk (sclk), .sdin (sdin), .cs_n (cs_n),
        .ldac_n (ldac_n), .clr_n (clr_n), .clr_mid (clr_mid),
        .dac_codes (dac_codes), .proto_err (proto_err)
    );

    always @(posedge clk) if (!rst && proto_err) err_pulses++;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic check_all(input string tag);
        for (int ch = 0; ch < NCH; ch++)
            check(tag, 32'(dac_codes[ch*CODE_W +: CODE_W]), 32'(exp_m[ch]));
    endtask

    task automatic begin_frame();
        cs_n = 1'b0; tick(2);
    endtask

    task automatic end_frame();
        cs_n = 1'b1; tick(2);
    endtask

    task automatic shift_bit(input logic b);
        sclk = 1'b0; sdin = b; tick(2);
        sclk = 1'b1; tick(2);
        sh_m = {sh_m[FRAME_W-2:0], b};
        if (!ldac_n) exp_pulses++;
    endtask

    task automatic send(input logic [31:0] w, input int n);
        begin_frame();
        for (int i = n - 1; i >= 0; i--) shift_bit(w[i]);
        end_frame();
    endtask

    task automatic strobe();
        ldac_n = 1'b0; tick(4);
        if (clr_n) exp_m[sh_m[15:14]] = sh_m[11:0];
        ldac_n = 1'b1; tick(4);
    endtask

    task automatic do_clear(input logic mid);
        clr_mid = mid; clr_n = 1'b0; tick(4);
        for (int ch = 0; ch < NCH; ch++) exp_m[ch] = mid ? 12'h800 : 12'h000;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(20 * 150000);
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        for (int ch = 0; ch < NCH; ch++) exp_m[ch] = '0;
        tick(3);
        // R1: reset state
        check_all("R1 reset code");
        check("R1 proto_err", 32'(proto_err), 32'd0);
        rst = 1'b0; tick(4);

        // R2, R3: sweep over every channel and several codes
        for (int ch = 0; ch < NCH; ch++) begin
            for (int k = 0; k < 4; k++) begin
                logic [11:0] code;
                code = (k == 0) ? 12'h000 : (k == 1) ? 12'hFFF
                     : 12'((ch * 'h3A7 + k * 'h5C1) & 'hFFF);
                send({16'h0, 2'(ch), 2'(k), code}, 16);
                strobe();
                check_all("R2 R3 addressed load");
            end
        end

        // R4: longer burst, last 16 bits count
        send(32'h000A3C5E, 20);
        strobe();
        check_all("R4 last sixteen bits");

        // R5: deselected clocks shift nothing
        send(32'h0000B123, 16);
        for (int i = 0; i < 6; i++) begin
            sdin = i[0]; sclk = 1'b0; tick(2); sclk = 1'b1; tick(2);
        end
        strobe();
        check_all("R5 select high ignores data");
        check("R5 channel C", 32'(dac_codes[35:24]), 32'h123);

        // R6: select rising while clock low adds a false bit
        begin_frame();
        for (int i = 15; i >= 0; i--) shift_bit(16'h2ABC >> i);
        sclk = 1'b0; sdin = 1'b1; tick(2);
        cs_n = 1'b1; tick(2);
        sh_m = {sh_m[FRAME_W-2:0], 1'b1};
        sclk = 1'b1; tick(2);
        strobe();
        check_all("R6 false bit");
        check("R6 channel B", 32'(dac_codes[23:12]), 32'h579);

        // R7: load with select still low
        begin_frame();
        for (int i = 15; i >= 0; i--) shift_bit(16'hC9D4 >> i);
        strobe();
        check_all("R7 load with select low");
        end_frame();

        // R8, R9: zero-scale clear, hold after release, reload
        do_clear(1'b0);
        check_all("R8 zero-scale clear");
        clr_n = 1'b1; tick(4);
        check_all("R9 hold after clear");
        strobe();
        check_all("R9 reload shifted word");
        check("R9 channel D", 32'(dac_codes[47:36]), 32'h9D4);

        // R8, R10: midscale clear with strobe edge inside the clear
        do_clear(1'b1);
        check_all("R8 midscale clear");
        ldac_n = 1'b0; tick(4);
        clr_n = 1'b1; tick(4);
        ldac_n = 1'b1; tick(4);
        check_all("R10 load discarded under clear");

        // R11: no pulses so far, then shifting with strobe low
        check("R11 no error pulses", 32'(err_pulses), 32'(exp_pulses));
        strobe();
        ldac_n = 1'b0; tick(4);
        exp_m[sh_m[15:14]] = sh_m[11:0];
        begin_frame();
        shift_bit(1'b1); shift_bit(1'b0); shift_bit(1'b1);
        ldac_n = 1'b1; tick(4);
        end_frame();
        tick(4);
        check("R11 error pulses", 32'(err_pulses), 32'(exp_pulses));
        check("R11 pulse count", 32'(exp_pulses), 32'd3);
        check_all("R11 no load while shifting");

        finish_run();
    end
endmodule